// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request inputs and drives one active-low request line toward a processor. Each input has its own configuration word holding a priority, a trigger mode and a vector address. Inputs can be high-level, low-level, rising-edge or falling-edge triggered. Each can be switched in or out of arbitration through separate enable-set and enable-clear writes.

Software acknowledges an interrupt by reading the vector register. The read returns the vector of the winning source, pushes that source's priority onto a hardware stack of in-service levels, and releases the request line. A request is raised again only when a pending source beats the level on top of the stack. The handler ends by writing the end-of-interrupt register, which pops the stack and returns to the level that was in service before. This lets a higher-priority interrupt preempt a running handler.

A three-state controller (`ST_IDLE`, `ST_REQ`, `ST_SVC`) drives the request line, which is low only in `ST_REQ`. Its transitions are evaluated in this order on each clock:
- Acknowledge: a vector read that takes effect moves the controller to `ST_SVC`.
- Retire: an end-of-interrupt write with one level left moves it to `ST_IDLE`. With more than one level left it moves to `ST_SVC`.
- Raise: an eligible winner moves it to `ST_REQ`.
- Settle: otherwise the controller goes to `ST_SVC` if the stack holds a level, and to `ST_IDLE` if it does not.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A write to address i (for i below NUM_SRC) sets the configuration of source i. Bits [2:0] hold the priority (0 lowest, 7 highest). Bits [5:4] hold the trigger mode: 0 high-level, 1 low-level, 2 rising-edge, 3 falling-edge. Bits [31:8] hold the 24-bit vector.
- R2: Writing address 10 enables every source whose data bit is 1. Writing address 11 disables every source whose data bit is 1. A disabled source never wins arbitration, but it still latches edges, and a latched edge is served once the source is enabled.
- R3: The winner is the enabled pending source with the highest priority. On equal priorities, the lower source number wins.
- R4: The request line goes low one clock after a winner exists and either the stack is empty or the winner's priority is strictly higher than the level on top of the stack. An equal or lower priority does not raise it.
- R5: A read of address 8 while the request condition of R4 holds does three things. It returns the winner's vector in bits [23:0] with zeros above, pushes the winner's priority onto the stack, and drives the request line high on the next clock.
- R6: A read of address 8 while the request condition does not hold returns zero and changes no state.
- R7: An acknowledge clears the latched edge of the winning edge-triggered source. A level-triggered source is not cleared by an acknowledge and stays pending while its input is active.
- R8: A write to address 9 pops the top level from the stack and restores the previous level as current. With an empty stack the write is ignored.
- R9: After a pop, a pending source whose priority is at or below the popped level but above the restored level raises the request line again.
- R10: The stack holds NUM_PRIO levels, so one handler per priority level can be nested.
- R11: After reset the request line is high, the stack is empty, all sources are disabled, and all configuration fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | NUM_SRC | Raw interrupt request inputs, one bit per source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; carries the vector on an acknowledging read, zero otherwise |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench builds the block with its defaults: eight sources, eight priority levels and a 24-bit vector. With these values the stack can be filled to full depth by enabling one source per level in rising order. All four trigger modes can be exercised side by side, along with priority ties and re-raise after a pop. A behavioural model in the bench predicts the request line and the read data on every cycle.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SVC  = 2'd2
    } ctl_st_e;

    localparam int CFG_MODE_LSB = 4;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import nirq_pkg::*;
#(
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src,
    input  logic              cfg_we,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [1:0]        cfg_mode,
    input  logic [VEC_W-1:0]  cfg_vec,
    input  logic              en_set,
    input  logic              en_clr,
    input  logic              ack_clr,
    output logic              pend,
    output logic [PRIO_W-1:0] prio,
    output logic [VEC_W-1:0]  vec
);
    trig_e             mode_q;
    logic [PRIO_W-1:0] prio_q;
    logic [VEC_W-1:0]  vec_q;
    logic              en_q, src_q, edge_q, edge_hit, raw;

    always_comb begin
        unique case (mode_q)
            TRIG_RISE: edge_hit = src & ~src_q;
            TRIG_FALL: edge_hit = ~src & src_q;
            default:   edge_hit = 1'b0;
        endcase
        unique case (mode_q)
            TRIG_HIGH: raw = src;
            TRIG_LOW:  raw = ~src;
            default:   raw = edge_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= TRIG_HIGH;
            prio_q <= '0;
            vec_q  <= '0;
            en_q   <= 1'b0;
            src_q  <= 1'b0;
            edge_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                prio_q <= cfg_prio;
                mode_q <= trig_e'(cfg_mode);
                vec_q  <= cfg_vec;
            end
            if (en_set)      en_q <= 1'b1;
            else if (en_clr) en_q <= 1'b0;
            src_q  <= src;
            edge_q <= (edge_q & ~ack_clr) | edge_hit;
        end
    end

    assign pend = en_q & raw;
    assign prio = prio_q;
    assign vec  = vec_q;

    // R7: an acknowledged edge with no fresh edge leaves nothing latched
    p_edge_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && (mode_q == TRIG_RISE || mode_q == TRIG_FALL) && !edge_hit) |=> !edge_q);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic                           win_valid,
    output logic [SRC_W-1:0]               win_idx,
    output logic [PRIO_W-1:0]              win_prio
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        // scanning downward with >= lets the lower index win ties
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i] && (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = SRC_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int DEPTH  = 8,
    parameter int LVL_W  = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic             empty,
    output logic [LVL_W-1:0] top_lvl,
    output logic [CNT_W-1:0] depth
);
    logic [LVL_W-1:0] lvl_q [DEPTH];
    logic [CNT_W-1:0] depth_q;
    logic             full;

    assign full    = (depth_q == CNT_W'(DEPTH));
    assign empty   = (depth_q == '0);
    assign depth   = depth_q;
    assign top_lvl = empty ? '0 : lvl_q[IDX_W'(depth_q - 1'b1)];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
            for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
        end else if (push && !full) begin
            lvl_q[depth_q[IDX_W-1:0]] <= push_lvl;
            depth_q <= depth_q + 1'b1;
        end else if (pop && !empty) begin
            depth_q <= depth_q - 1'b1;
        end
    end

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_PRIO = 8,
    parameter int VEC_W    = 24,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_src,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);
    localparam int PRIO_W     = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
    localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CNT_W      = $clog2(NUM_PRIO + 1);
    localparam int VEC_LSB    = DATA_W - VEC_W;
    localparam int ADDR_VEC   = NUM_SRC;
    localparam int ADDR_EOI   = NUM_SRC + 1;
    localparam int ADDR_ENSET = NUM_SRC + 2;
    localparam int ADDR_ENCLR = NUM_SRC + 3;

    logic [NUM_SRC-1:0]             pend, ack_clr;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_arr;
    logic [VEC_W-1:0]               vec_arr [NUM_SRC];
    logic                           win_valid, eligible, ack_fire, eoi_fire;
    logic                           en_set_wr, en_clr_wr, stk_empty;
    logic [SRC_W-1:0]               win_idx;
    logic [PRIO_W-1:0]              win_prio, top_lvl;
    logic [CNT_W-1:0]               stk_depth;
    ctl_st_e                        state_q, state_d;

    assign en_set_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_ENSET));
    assign en_clr_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_ENCLR));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell #(.PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (irq_src[g]),
            .cfg_we   (bus_wr && (bus_addr == ADDR_W'(g))),
            .cfg_prio (bus_wdata[PRIO_W-1:0]),
            .cfg_mode (bus_wdata[CFG_MODE_LSB +: 2]),
            .cfg_vec  (bus_wdata[VEC_LSB +: VEC_W]),
            .en_set   (en_set_wr && bus_wdata[g]),
            .en_clr   (en_clr_wr && bus_wdata[g]),
            .ack_clr  (ack_clr[g]),
            .pend     (pend[g]),
            .prio     (prio_arr[g]),
            .vec      (vec_arr[g])
        );
        assign ack_clr[g] = ack_fire && (win_idx == SRC_W'(g));
    end

    irq_prio_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
        .req       (pend),
        .prio      (prio_arr),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    assign eligible = win_valid && (stk_empty || win_prio > top_lvl);
    assign ack_fire = bus_rd && (bus_addr == ADDR_W'(ADDR_VEC)) && eligible;
    assign eoi_fire = bus_wr && (bus_addr == ADDR_W'(ADDR_EOI)) && !stk_empty;

    irq_level_stack #(.DEPTH(NUM_PRIO), .LVL_W(PRIO_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_fire),
        .push_lvl (win_prio),
        .pop      (eoi_fire),
        .empty    (stk_empty),
        .top_lvl  (top_lvl),
        .depth    (stk_depth)
    );

    assign bus_rdata = ack_fire ? DATA_W'(vec_arr[win_idx]) : '0;

    // Transitions: acknowledge, retire, raise, settle
    always_comb begin
        if (ack_fire)
            state_d = ST_SVC;
        else if (eoi_fire)
            state_d = (stk_depth == CNT_W'(1)) ? ST_IDLE : ST_SVC;
        else if (eligible)
            state_d = ST_REQ;
        else
            state_d = stk_empty ? ST_IDLE : ST_SVC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_REQ:  irq_n = 1'b0;
            ST_IDLE: irq_n = 1'b1;
            ST_SVC:  irq_n = 1'b1;
            default: irq_n = 1'b1;
        endcase
    end

    p_req_only_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(eligible));
    p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> irq_n);
    p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADDR_EOI) && stk_empty) |=> stk_empty);
    p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_fire |=> stk_depth == CNT_W'($past(stk_depth) - 1'b1));
endmodule

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_src = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    nest_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0, errors = 0;
    string tag = "R11";
    bit    done = 1'b0;

    // behavioural reference state
    int          m_prio [NS];
    int          m_mode [NS];
    logic [23:0] m_vec  [NS];
    logic [7:0]  m_en = '0, m_lat = '0, m_prev = '0;
    int          m_stk [$];
    logic        m_irq_n = 1'b1;

    initial for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_mode[i] = 0; m_vec[i] = '0; end

    function automatic void m_eval(output bit elig, output int w);
        bit found = 0; int best = 0; w = 0;
        for (int i = 0; i < NS; i++) begin
            bit p;
            if (m_mode[i] == 0)      p = irq_src[i];
            else if (m_mode[i] == 1) p = !irq_src[i];
            else                     p = m_lat[i];
            if (m_en[i] && p && (!found || m_prio[i] > best)) begin
                found = 1; best = m_prio[i]; w = i;
            end
        end
        elig = found && (m_stk.size() == 0 || best > m_stk[$]);
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        bit el; int w; bit ack, eoi; logic [31:0] exp_rd;
        #1;
        m_eval(el, w);
        exp_rd = (bus_rd && bus_addr == 4'd8 && el) ? {8'h00, m_vec[w]} : 32'h0;
        check(32'(irq_n), 32'(m_irq_n), "irq_n");
        check(bus_rdata, exp_rd, "rdata");
        @(posedge clk);
        ack = bus_rd && bus_addr == 4'd8 && el;
        eoi = bus_wr && bus_addr == 4'd9 && m_stk.size() > 0;
        m_irq_n = (ack || eoi) ? 1'b1 : !el;
        for (int i = 0; i < NS; i++) begin
            bit e;
            e = (m_mode[i] == 2 && irq_src[i] && !m_prev[i]) ||
                (m_mode[i] == 3 && !irq_src[i] && m_prev[i]);
            m_lat[i] = (m_lat[i] && !(ack && w == i)) || e;
        end
        m_prev = irq_src;
        if (ack) m_stk.push_back(m_prio[w]);
        if (eoi) void'(m_stk.pop_back());
        if (bus_wr && bus_addr < 4'd8) begin
            m_prio[bus_addr] = int'(bus_wdata[2:0]);
            m_mode[bus_addr] = int'(bus_wdata[5:4]);
            m_vec[bus_addr]  = bus_wdata[31:8];
        end
        if (bus_wr && bus_addr == 4'd10) m_en = m_en | bus_wdata[7:0];
        if (bus_wr && bus_addr == 4'd11) m_en = m_en & ~bus_wdata[7:0];
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic cfg(int i, int pr, int md, logic [23:0] v);
        wr(4'(i), {v, 2'b00, 2'(md), 1'b0, 3'(pr)});
    endtask

    task automatic rd_expect(logic [31:0] exp);
        bus_rd = 1'b1; bus_addr = 4'd8;
        #1 check(bus_rdata, exp, "vector read");
        step();
        bus_rd = 1'b0;
    endtask

    task automatic chk_irq(logic exp);
        #1 check(32'(irq_n), 32'(exp), "irq_n direct");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R11";
        chk_irq(1'b1);
        check(bus_rdata, 32'h0, "rdata after reset");
        idle(2);

        tag = "R1";
        cfg(2, 3, 0, 24'h222222);
        cfg(5, 5, 2, 24'h555555);
        cfg(3, 6, 3, 24'h333333);
        cfg(0, 4, 0, 24'h0A0A0A);
        cfg(1, 4, 0, 24'h1B1B1B);
        cfg(6, 2, 2, 24'h666666);
        cfg(4, 1, 1, 24'h444444);
        cfg(7, 7, 0, 24'h777777);

        tag = "R2";
        idle(2);
        chk_irq(1'b1);

        tag = "R4";
        wr(4'd10, 32'h04);
        irq_src[2] = 1'b1;
        step();
        chk_irq(1'b0);
        tag = "R5";
        rd_expect(32'h00222222);
        chk_irq(1'b1);
        tag = "R4";
        idle(3);
        chk_irq(1'b1);

        tag = "R3";
        wr(4'd10, 32'h20);
        irq_src[5] = 1'b1; step();
        irq_src[5] = 1'b0; step();
        chk_irq(1'b0);
        tag = "R5";
        rd_expect(32'h00555555);

        tag = "R4";
        wr(4'd10, 32'h03);
        irq_src[0] = 1'b1; irq_src[1] = 1'b1;
        idle(3);
        chk_irq(1'b1);

        tag = "R9";
        wr(4'd9, 32'h0);
        step();
        chk_irq(1'b0);
        tag = "R3";
        rd_expect(32'h000A0A0A);
        tag = "R7";
        wr(4'd9, 32'h0);
        step();
        chk_irq(1'b0);
        rd_expect(32'h000A0A0A);
        irq_src[0] = 1'b0; irq_src[1] = 1'b0;
        wr(4'd9, 32'h0);
        idle(2);
        chk_irq(1'b1);
        wr(4'd9, 32'h0);
        step();
        chk_irq(1'b0);
        rd_expect(32'h00222222);
        irq_src[2] = 1'b0;
        wr(4'd9, 32'h0);
        idle(2);
        chk_irq(1'b1);

        tag = "R8";
        wr(4'd9, 32'h0);
        wr(4'd10, 32'h10);
        step();
        chk_irq(1'b0);
        rd_expect(32'h00444444);
        wr(4'd9, 32'h0);
        step();
        chk_irq(1'b0);
        rd_expect(32'h00444444);
        wr(4'd9, 32'h0);
        tag = "R2";
        wr(4'd11, 32'h10);
        idle(2);
        chk_irq(1'b1);

        irq_src[6] = 1'b1; step();
        irq_src[6] = 1'b0; idle(2);
        chk_irq(1'b1);
        wr(4'd10, 32'h40);
        step();
        chk_irq(1'b0);
        rd_expect(32'h00666666);
        wr(4'd9, 32'h0);

        tag = "R7";
        wr(4'd10, 32'h08);
        irq_src[3] = 1'b1; idle(2);
        chk_irq(1'b1);
        irq_src[3] = 1'b0; idle(2);
        chk_irq(1'b0);
        rd_expect(32'h00333333);
        wr(4'd9, 32'h0);
        idle(2);
        chk_irq(1'b1);

        tag = "R6";
        rd_expect(32'h0);
        idle(2);
        chk_irq(1'b1);

        tag = "R10";
        wr(4'd11, 32'hFF);
        for (int i = 0; i < NS; i++) cfg(i, i, 0, 24'h100000 + 24'(i));
        irq_src = 8'hFF;
        idle(2);
        for (int i = 0; i < NS; i++) begin
            wr(4'd10, 32'(1) << i);
            step();
            chk_irq(1'b0);
            rd_expect(32'h00100000 + 32'(i));
        end
        idle(2);
        chk_irq(1'b1);
        for (int i = 0; i < NS; i++) begin
            wr(4'd9, 32'h0);
            step();
        end
        chk_irq(1'b0);
        wr(4'd11, 32'hFF);
        idle(3);
        chk_irq(1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule